// File: doc/BRIEF.md
# ADC Sample Capture DMA Engine

This engine moves finished converter results into byte-wide external data memory without any help from the processor. While it is enabled it keeps asking the conversion controller for new conversions. Each result it receives is a 16-bit word: a 4-bit channel tag on top of a 12-bit conversion value. The engine writes that word to memory as two bytes.

A 24-bit pointer walks through a programmed window of up to 16 MB. The engine stops and raises a done flag once the next byte pair would no longer fit in the window. A result that arrives while the previous pair is still being written is dropped, and a sticky overrun flag is set. Clearing the enable lets the pair in flight finish and then parks the engine. The pointer stays visible after that.

Top module: `adc_capture_dma`

## Requirements
- R1: After reset the engine is idle: `memWr`, `convReq`, `done` and `overrun` are 0 and `curAddr` is 0.
- R2: When `enable` is high in the idle state, one clock edge copies `startAddr` into `curAddr`, latches `endAddr`, clears `overrun` and `done`, and starts capture with `convReq` high.
- R3: A result accepted while waiting is written as two bytes. The high byte `resWord[15:8]` (channel tag in bits 7:4) goes to `curAddr`, then the low byte `resWord[7:0]` goes to `curAddr+1`. Each byte write starts one cycle after the previous step.
- R4: A byte write keeps `memWr`, `memAddr` and `memData` steady until a cycle in which `memRdy` is high; that cycle completes the byte.
- R5: When the low byte completes, `curAddr` advances by exactly 2. It changes in no other way while capture runs.
- R6: After a pair completes, if `curAddr+3` exceeds the latched end address, the engine enters done. It raises `done`, drops `convReq` and makes no writes until `enable` goes low.
- R7: If `startAddr+1` exceeds `endAddr` at start, the engine goes straight to done with no writes.
- R8: A result that arrives while either byte of a pair is being written is discarded and sets `overrun`. `overrun` stays set until the next start.
- R9: With `enable` low, a waiting engine returns to idle at the next edge. An engine in the middle of a pair finishes both bytes first. In both cases `curAddr` keeps its final value and `convReq` falls.
- R10: Results that arrive while idle or done cause no write and leave `overrun` unchanged.
- R11: `convReq` is high exactly while capture is running: waiting, or writing either byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| startAddr | input | 24 | First byte address of the window |
| endAddr | input | 24 | Last byte address of the window |
| resValid | input | 1 | Result word present this cycle |
| resWord | input | 16 | Channel tag [15:12] and conversion value [11:0] |
| convReq | output | 1 | Continuous conversion request |
| memWr | output | 1 | Byte write strobe |
| memAddr | output | 24 | Byte write address |
| memData | output | 8 | Byte write data |
| memRdy | input | 1 | Memory accepts the current byte |
| curAddr | output | 24 | Address pointer |
| done | output | 1 | Window full |
| overrun | output | 1 | Sticky dropped-result flag |

## Verification
All outputs come from registers, so every effect of a stimulus shows up one clock edge after it is sampled:
- an accepted result makes the high-byte write appear on the next cycle;
- a completed low byte moves `curAddr` and `done`, or reopens the wait, on the next cycle;
- a late result sets `overrun` on the next cycle.

Inputs change just after a rising edge. A behavioural model advances on the same edge. The ports are compared with the model at every falling edge, so each result is checked in the exact cycle it is due. Extra named checks after each scenario cover the start, stop, empty-window and top-of-memory cases.

// File: rtl/dma_cap_pkg.sv
package dma_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW,
    ST_FULL
  } capState_t;

  typedef struct packed {
    logic loadPtr;
    logic advPtr;
    logic capture;
    logic flagOvr;
    logic selLo;
  } dpStrobe_t;

endpackage

// File: rtl/dma_cap_ctrl.sv
module dma_cap_ctrl
  import dma_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       resValid,
  input  logic       memRdy,
  input  logic       startFits,
  input  logic       nextFits,
  output dpStrobe_t  strobe,
  output logic       memWr,
  output logic       done,
  output logic       convReq
);

  capState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          strobe.loadPtr = 1'b1;
          stateNext      = startFits ? ST_WAIT : ST_FULL;
        end
      end
      ST_WAIT: begin
        if (!enable) begin
          stateNext = ST_IDLE;
        end else if (resValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_HIGH;
        end
      end
      ST_HIGH: begin
        strobe.flagOvr = resValid;
        if (memRdy) stateNext = ST_LOW;
      end
      ST_LOW: begin
        strobe.flagOvr = resValid;
        strobe.selLo   = 1'b1;
        if (memRdy) begin
          strobe.advPtr = 1'b1;
          if (!enable)       stateNext = ST_IDLE;
          else if (nextFits) stateNext = ST_WAIT;
          else               stateNext = ST_FULL;
        end
      end
      ST_FULL: begin
        if (!enable) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memWr   = (state == ST_HIGH) || (state == ST_LOW);
  assign done    = (state == ST_FULL);
  assign convReq = (state == ST_WAIT) || memWr;

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    done && enable |=> done); // R6

  AST_WRITE_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWr) |-> $past(convReq)); // R11

endmodule

// File: rtl/dma_cap_dpath.sv
module dma_cap_dpath
  import dma_cap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]          startAddr,
  input  logic [ADDR_W-1:0]          endAddr,
  input  logic [TAG_W+DATA_W-1:0]    resWord,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [(TAG_W+DATA_W)/2-1:0] memData,
  output logic [ADDR_W-1:0]          curAddr,
  output logic                       overrun,
  output logic                       startFits,
  output logic                       nextFits
);

  localparam int WORD_W = TAG_W + DATA_W;
  localparam int BYTE_W = WORD_W / 2;
  localparam int WIDE_W = ADDR_W + 1;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] endReg;
  logic [WORD_W-1:0] holdWord;
  logic              ovrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      endReg   <= '0;
      holdWord <= '0;
      ovrReg   <= 1'b0;
    end else begin
      if (strobe.loadPtr) begin
        ptr    <= startAddr;
        endReg <= endAddr;
        ovrReg <= 1'b0;
      end else begin
        if (strobe.advPtr)  ptr    <= ptr + ADDR_W'(2);
        if (strobe.flagOvr) ovrReg <= 1'b1;
      end
      if (strobe.capture) holdWord <= resWord;
    end
  end

  assign startFits = ({1'b0, startAddr} + WIDE_W'(1)) <= {1'b0, endAddr};
  assign nextFits  = ({1'b0, ptr} + WIDE_W'(3)) <= {1'b0, endReg};

  assign memAddr = strobe.selLo ? ptr + ADDR_W'(1) : ptr;
  assign memData = strobe.selLo ? holdWord[BYTE_W-1:0] : holdWord[WORD_W-1:BYTE_W];
  assign curAddr = ptr;
  assign overrun = ovrReg;

  AST_PAIR_FITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advPtr |-> ({1'b0, ptr} + WIDE_W'(1)) <= {1'b0, endReg}); // R6

endmodule

// File: rtl/adc_capture_dma.sv
module adc_capture_dma
  import dma_cap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [ADDR_W-1:0]           endAddr,
  input  logic                        resValid,
  input  logic [TAG_W+DATA_W-1:0]     resWord,
  output logic                        convReq,
  output logic                        memWr,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [(TAG_W+DATA_W)/2-1:0] memData,
  input  logic                        memRdy,
  output logic [ADDR_W-1:0]           curAddr,
  output logic                        done,
  output logic                        overrun
);

  dpStrobe_t strobe;
  logic      startFits;
  logic      nextFits;

  dma_cap_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .resValid  (resValid),
    .memRdy    (memRdy),
    .startFits (startFits),
    .nextFits  (nextFits),
    .strobe    (strobe),
    .memWr     (memWr),
    .done      (done),
    .convReq   (convReq)
  );

  dma_cap_dpath #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .resWord   (resWord),
    .memAddr   (memAddr),
    .memData   (memData),
    .curAddr   (curAddr),
    .overrun   (overrun),
    .startFits (startFits),
    .nextFits  (nextFits)
  );

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memWr && !memRdy |=> memWr && $stable(memAddr) && $stable(memData)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curAddr) && $past(convReq) |-> curAddr == $past(curAddr) + ADDR_W'(2)); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && convReq |=> overrun); // R8

endmodule

// File: tb/test_adc_capture_dma.sv
`timescale 1ns/1ps
module test_adc_capture_dma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [23:0] startAddr = '0;
  logic [23:0] endAddr = '0;
  logic        resValid = 1'b0;
  logic [15:0] resWord = '0;
  logic        convReq, memWr, memRdy = 1'b0, done, overrun;
  logic [23:0] memAddr, curAddr;
  logic [7:0]  memData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_capture_dma i_adc_capture_dma (
    .clk(clk), .rstN(rstN), .enable(enable), .startAddr(startAddr),
    .endAddr(endAddr), .resValid(resValid), .resWord(resWord),
    .convReq(convReq), .memWr(memWr), .memAddr(memAddr), .memData(memData),
    .memRdy(memRdy), .curAddr(curAddr), .done(done), .overrun(overrun)
  );

  // Behavioural reference: phase 0 idle, 1 wait, 2 high byte, 3 low byte, 4 full
  int          mPhase = 0;
  longint      mPtr = 0;
  longint      mEnd = 0;
  logic [15:0] mHold = '0;
  bit          mOvr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mPtr = 0; mEnd = 0; mHold = '0; mOvr = 0;
    end else begin
      case (mPhase)
        0: if (enable) begin
             mPtr = startAddr; mEnd = endAddr; mOvr = 0;
             mPhase = (longint'(startAddr) + 1 > longint'(endAddr)) ? 4 : 1;
           end
        1: if (!enable) mPhase = 0;
           else if (resValid) begin mHold = resWord; mPhase = 2; end
        2: begin
             if (resValid) mOvr = 1;
             if (memRdy) mPhase = 3;
           end
        3: begin
             if (resValid) mOvr = 1;
             if (memRdy) begin
               if (!enable) mPhase = 0;
               else if (mPtr + 3 > mEnd) mPhase = 4;
               else mPhase = 1;
               mPtr = (mPtr + 2) & 64'hFFFFFF;
             end
           end
        default: if (!enable) mPhase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic bit expWr = (mPhase == 2) || (mPhase == 3);
      automatic logic [23:0] expAddr = 24'((mPtr + ((mPhase == 3) ? 1 : 0)) & 64'hFFFFFF);
      automatic logic [7:0] expData = (mPhase == 3) ? mHold[7:0] : mHold[15:8];
      check(memWr == expWr, "R4 memWr", memWr, expWr);
      if (expWr) begin
        check(memAddr == expAddr, "R3 memAddr", memAddr, expAddr);
        check(memData == expData, "R3 memData", memData, expData);
      end
      check(curAddr == 24'(mPtr), "R5 curAddr", curAddr, mPtr);
      check(done == (mPhase == 4), "R6 done", done, mPhase == 4);
      check(overrun == mOvr, "R8 overrun", overrun, mOvr);
      check(convReq == (mPhase >= 1 && mPhase <= 3), "R11 convReq", convReq,
            mPhase >= 1 && mPhase <= 3);
    end
  end

  task automatic step(input bit v, input logic [15:0] w, input bit r);
    resValid = v; resWord = w; memRdy = r;
    @(posedge clk); #1;
  endtask

  // one result, stalled for 'stall' cycles on the high byte, optional late result
  task automatic sample(input logic [15:0] w, input int stall, input bit late);
    step(1, w, 0);
    for (int k = 0; k < stall; k++) step(late && k == 0, 16'hDEAD, 0);
    step(0, 16'h0, 1);
    step(0, 16'h0, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!memWr && !convReq && !done && !overrun, "R1 idle flags",
          {memWr, convReq, done, overrun}, 0);
    check(curAddr == 0, "R1 curAddr", curAddr, 0);
    rstN = 1'b1;
    step(0, 0, 0);

    // window of 12 bytes: six results
    startAddr = 24'h000100; endAddr = 24'h00010B; enable = 1'b1;
    step(0, 0, 0);
    check(curAddr == 24'h000100 && convReq, "R2 start", curAddr, 24'h000100);
    for (int i = 0; i < 6; i++) begin
      sample({4'(i + 2), 12'(12'h3A0 + i * 17)}, i % 3, i == 1);
      step(0, 0, 1);
    end
    check(overrun, "R8 late result flagged", overrun, 1);
    check(done && !convReq, "R6 window full", done, 1);
    check(curAddr == 24'h00010C, "R5 final pointer", curAddr, 24'h00010C);
    step(1, 16'h1234, 1);
    step(0, 0, 1);
    check(!memWr && done, "R10 ignored while done", memWr, 0);

    // stop and keep pointer
    enable = 1'b0;
    step(0, 0, 0);
    check(!done && !convReq && curAddr == 24'h00010C, "R9 stopped", curAddr, 24'h00010C);
    step(1, 16'h5555, 1);
    step(0, 0, 0);
    check(!memWr && overrun, "R10 ignored while idle", memWr, 0);

    // empty window
    startAddr = 24'h000005; endAddr = 24'h000005; enable = 1'b1;
    step(0, 0, 1);
    check(done && !memWr, "R7 empty window", done, 1);
    check(curAddr == 24'h000005, "R7 pointer", curAddr, 5);
    enable = 1'b0;
    step(0, 0, 0);

    // stop in the middle of a pair
    startAddr = 24'h000020; endAddr = 24'h0000FF; enable = 1'b1;
    step(0, 0, 0);
    check(!overrun, "R2 overrun cleared", overrun, 0);
    step(1, 16'h9ABC, 0);
    enable = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);
    check(memWr, "R9 pair continues", memWr, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    check(!convReq && curAddr == 24'h000022, "R9 pair finished", curAddr, 24'h000022);

    // top of memory, back-to-back results
    startAddr = 24'hFFFFF8; endAddr = 24'hFFFFFE; enable = 1'b1;
    step(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, {4'hF, 12'(12'hF00 + i)}, 1);
      step(0, 0, 1);
      step(0, 0, 1);
    end
    check(done && curAddr == 24'hFFFFFE, "R6 top window", curAddr, 24'hFFFFFE);
    enable = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule